// File: doc/BRIEF.md
# Video Coprocessor Command Mailbox

This block is the register file that sits between a host processor and a video coprocessor. Through a word-addressed host port, software posts a pointer to the next command. It also starts and resets the coprocessor, exchanges interrupts with it and reads its progress flags. The mailbox holds two command pointers. The pending pointer is written by the host. The active pointer, driven out on `cmd_ptr_o`, is loaded from the pending one only on a fetch event. That event is either a rising edge of the hardware field sync or, in software mode, a host post. This lets the host prepare the next command while the current one is in use.

A five-state sequencer controls the block. ST_HALT is the state after power-on and after any reset. Writing the fetch-enable bit moves it from ST_HALT to ST_BOOT. A soft-reset request moves it from any state to ST_RESET. ST_RESET returns to ST_HALT after `RST_CYCLES` cycles, raising the reset-done flag. ST_BOOT moves to ST_IDLE after `BOOT_CYCLES` cycles, raising the queues-initialised flag. In ST_IDLE, a fetch event with a non-zero pending pointer loads it and moves to ST_BUSY. In ST_BUSY, a fetch event with a non-zero pointer reloads it and stays. A fetch event with a zero pointer clears the active pointer and moves back to ST_IDLE. A zero pointer therefore means idle.

Top module: `vid_cmd_mailbox`

## Requirements
- R1: After reset every register reads 0, all outputs are 0 and the sequencer is halted. Word offsets: 0x00 coprocessor doorbell, 0x04 host info, 0x08 host interrupt, 0x0C coprocessor status, 0x10 soft reset, 0x14 startup-1, 0x18 startup-2, 0x1C general scratch, 0x20 pending pointer, 0x24 active pointer, 0x28 sync mode.
- R2: Writing 0x10 with bit 0 set (full) or bit 1 set (core) pulses `rst_full_o` or `rst_core_o` for exactly one cycle, and the register then reads 0. Both kinds clear the active pointer and fetch enable. A full reset also clears host info, scratch, the pending pointer, the sync mode and the idle-authorise bit. A core reset keeps them.
- R3: Reset-done (0x14 bit 0) is 0 for `RST_CYCLES`-1 cycles after the reset-request edge and is 1 from the `RST_CYCLES`-th edge on.
- R4: Writing 0x18 with bit 1 set drives `fetch_en_o` high. From halt, after `BOOT_CYCLES` edges, 0x0C reads ready (bit 15) together with queues-initialised (bit 13), which is 0xA000.
- R5: 0x14 bit 2 (idle authorise) is read/write. Bit 0 is read-only.
- R6: In a hardware sync mode (0x28 bit 0 = 0), a rising edge of `vsync_i` loads a non-zero pending pointer into the active pointer at that clock edge. 0x0C then reads processing (bit 14) plus bit 13, which is 0x6000. Posting alone changes nothing.
- R7: A fetch event with a zero pending pointer clears the active pointer and 0x0C returns to 0xA000.
- R8: In a software mode (value 1 or 3), `vsync_i` edges do not fetch. A write to 0x20 fetches its value one cycle after the write edge.
- R9: Each `vsync_i` rising edge gives a one-cycle `vsync_irq_o` pulse, except in mode 3.
- R10: Fetch events in halt, reset or boot states leave the active pointer unchanged.
- R11: Writing 1 to 0x00 bit 0 gives a one-cycle `irq_cp_o` pulse.
- R12: `cp_irq_req_i` sets the host interrupt (0x08 bit 0, `irq_host_o`). A host write of 1 to that bit clears it, a write of 0 has no effect, and a set wins over a simultaneous clear.
- R13: Host writes to 0x0C and 0x24 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_wr_en | input | 1 | Host write strobe |
| h_addr | input | ADDR_W | Host byte address (word aligned) |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data for h_addr |
| vsync_i | input | 1 | Hardware field sync |
| cp_irq_req_i | input | 1 | Coprocessor request to interrupt the host |
| rst_full_o | output | 1 | Full reset pulse to coprocessor |
| rst_core_o | output | 1 | Core reset pulse to coprocessor |
| fetch_en_o | output | 1 | Instruction fetch enable |
| irq_cp_o | output | 1 | Doorbell pulse to coprocessor |
| irq_host_o | output | 1 | Interrupt to host |
| vsync_irq_o | output | 1 | Field sync interrupt pulse |
| host_info_o | output | DATA_W | Host info word for the coprocessor |
| cmd_ptr_o | output | DATA_W | Active command pointer |

## Verification
The hardest situation to reach is a fetch event in each sync mode while the sequencer is in each state. A promotion is only visible once reset has finished and boot has completed. The stimulus therefore first runs a full reset, then fires a field sync while still halted, and only then boots. After boot it steps through the three sync-mode values, sending both field syncs and host posts in each, so that the effect of every event source is told apart from the others. A core reset after that shows which host state survives.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam logic [3:0] W_IRQ_CP    = 4'h0;
    localparam logic [3:0] W_HOST_INFO = 4'h1;
    localparam logic [3:0] W_IRQ_HOST  = 4'h2;
    localparam logic [3:0] W_CP_INFO   = 4'h3;
    localparam logic [3:0] W_SWRST     = 4'h4;
    localparam logic [3:0] W_START1    = 4'h5;
    localparam logic [3:0] W_START2    = 4'h6;
    localparam logic [3:0] W_GPSTAT    = 4'h7;
    localparam logic [3:0] W_NEXT      = 4'h8;
    localparam logic [3:0] W_CUR       = 4'h9;
    localparam logic [3:0] W_VSMODE    = 4'hA;

    localparam int INFO_READY = 15;
    localparam int INFO_PROC  = 14;
    localparam int INFO_QINIT = 13;
    localparam int SWRST_FULL = 0;
    localparam int SWRST_CORE = 1;
    localparam int ST1_DONE   = 0;
    localparam int ST1_IDLE   = 2;
    localparam int ST2_FETCH  = 1;

    localparam logic [1:0] VS_SW_QUIET = 2'd3;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_RESET,
        ST_BOOT,
        ST_IDLE,
        ST_BUSY
    } mbx_state_e;
endpackage

// File: rtl/mbx_vsync_sel.sv
module mbx_vsync_sel
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsync_i,
    input  logic [1:0] mode_i,
    input  logic       sw_trig_i,
    output logic       fetch_evt_o,
    output logic       vsync_irq_o
);
    logic vs_q;
    logic sw_pend_q;
    logic irq_q;
    logic hw_edge;

    assign hw_edge = vsync_i & ~vs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_q      <= 1'b0;
            sw_pend_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            vs_q      <= vsync_i;
            sw_pend_q <= sw_trig_i & mode_i[0];
            irq_q     <= hw_edge & (mode_i != VS_SW_QUIET);
        end
    end

    assign fetch_evt_o = mode_i[0] ? sw_pend_q : hw_edge;
    assign vsync_irq_o = irq_q;

    // R9: no sync interrupt while the quiet software mode was selected
    assert_quiet_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_irq_o |-> ($past(mode_i) != VS_SW_QUIET));
    // R8: software modes fetch only after a post
    assert_sw_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_evt_o && mode_i[0]) |-> $past(sw_trig_i));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_all_i,
    input  logic cp_set_i,
    input  logic host_clr_i,
    input  logic cp_irq_req_i,
    output logic irq_cp_o,
    output logic irq_host_o
);
    logic irq_cp_q;
    logic irq_host_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_cp_q   <= 1'b0;
            irq_host_q <= 1'b0;
        end else begin
            irq_cp_q <= cp_set_i;
            if (clr_all_i)         irq_host_q <= 1'b0;
            else if (cp_irq_req_i) irq_host_q <= 1'b1;
            else if (host_clr_i)   irq_host_q <= 1'b0;
        end
    end

    assign irq_cp_o   = irq_cp_q;
    assign irq_host_o = irq_host_q;

    // R11: doorbell pulse follows a doorbell write
    assert_doorbell_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cp_o |-> $past(cp_set_i));
    // R12: a coprocessor request is never lost to a host clear
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_irq_req_i && !clr_all_i) |=> irq_host_o);
endmodule

// File: rtl/mbx_fsm.sv
module mbx_fsm
    import mbx_pkg::*;
#(
    parameter int PTR_W       = 32,
    parameter int RST_CYCLES  = 8,
    parameter int BOOT_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req_i,
    input  logic             fetch_start_i,
    input  logic             fetch_evt_i,
    input  logic [PTR_W-1:0] next_ptr_i,
    output logic [PTR_W-1:0] cur_ptr_o,
    output logic             rst_done_o,
    output logic             qinit_o,
    output logic             ready_o,
    output logic             busy_o
);
    localparam int MAX_CYC = (RST_CYCLES > BOOT_CYCLES) ? RST_CYCLES : BOOT_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RST_LOAD  = CNT_W'(RST_CYCLES - 1);
    localparam logic [CNT_W-1:0] BOOT_LOAD = CNT_W'(BOOT_CYCLES - 1);

    mbx_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] cur_q;
    logic             done_q, qinit_q;
    logic             active;
    logic             next_zero;

    assign active    = (state_q == ST_IDLE) || (state_q == ST_BUSY);
    assign next_zero = (next_ptr_i == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HALT: begin
                if (fetch_start_i) begin
                    state_d = ST_BOOT;
                    cnt_d   = BOOT_LOAD;
                end
            end
            ST_RESET: begin
                if (cnt_q == '0) state_d = ST_HALT;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_BOOT: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_IDLE: begin
                if (fetch_evt_i && !next_zero) state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (fetch_evt_i && next_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_HALT;
        endcase
        if (rst_req_i) begin
            state_d = ST_RESET;
            cnt_d   = RST_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            done_q  <= 1'b0;
            qinit_q <= 1'b0;
        end else if (rst_req_i) begin
            cur_q   <= '0;
            done_q  <= 1'b0;
            qinit_q <= 1'b0;
        end else begin
            if (fetch_evt_i && active) cur_q <= next_ptr_i;
            if (state_q == ST_RESET && cnt_q == '0) done_q  <= 1'b1;
            if (state_q == ST_BOOT  && cnt_q == '0) qinit_q <= 1'b1;
        end
    end

    assign cur_ptr_o  = cur_q;
    assign rst_done_o = done_q;
    assign qinit_o    = qinit_q;
    assign ready_o    = (state_q == ST_IDLE);
    assign busy_o     = (state_q == ST_BUSY);

    // R6: a fetch in an active state loads the pending pointer
    assert_promote_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_evt_i && active && !rst_req_i) |=> (cur_ptr_o == $past(next_ptr_i)));
    // R10: halt, reset and boot leave the active pointer alone
    assert_hold_inactive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !rst_req_i) |=> $stable(cur_ptr_o));
    // R7: processing always has a live pointer, idle never does
    assert_busy_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cur_ptr_o != '0));
    assert_idle_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (cur_ptr_o == '0));
    // R3: reset-done rises only on leaving the reset state
    assert_done_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_done_o) |-> ($past(state_q) == ST_RESET));
endmodule

// File: rtl/vid_cmd_mailbox.sv
module vid_cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int RST_CYCLES  = 8,
    parameter int BOOT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr_en,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              vsync_i,
    input  logic              cp_irq_req_i,
    output logic              rst_full_o,
    output logic              rst_core_o,
    output logic              fetch_en_o,
    output logic              irq_cp_o,
    output logic              irq_host_o,
    output logic              vsync_irq_o,
    output logic [DATA_W-1:0] host_info_o,
    output logic [DATA_W-1:0] cmd_ptr_o
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic wr_irq_cp, wr_host_info, wr_irq_host, wr_swrst;
    logic wr_start1, wr_start2, wr_gp, wr_next, wr_mode;
    logic full_req, core_req, rst_req, fetch_start;

    logic [DATA_W-1:0] host_info_q, gp_q, next_q;
    logic [1:0]        mode_q;
    logic              idle_auth_q, fetch_en_q, rst_full_q, rst_core_q;

    logic              fetch_evt;
    logic [DATA_W-1:0] cur_ptr;
    logic              rst_done, qinit, ready, busy;

    assign widx         = h_addr[ADDR_W-1:2];
    assign wr_irq_cp    = h_wr_en && (widx == WIDX_W'(W_IRQ_CP));
    assign wr_host_info = h_wr_en && (widx == WIDX_W'(W_HOST_INFO));
    assign wr_irq_host  = h_wr_en && (widx == WIDX_W'(W_IRQ_HOST));
    assign wr_swrst     = h_wr_en && (widx == WIDX_W'(W_SWRST));
    assign wr_start1    = h_wr_en && (widx == WIDX_W'(W_START1));
    assign wr_start2    = h_wr_en && (widx == WIDX_W'(W_START2));
    assign wr_gp        = h_wr_en && (widx == WIDX_W'(W_GPSTAT));
    assign wr_next      = h_wr_en && (widx == WIDX_W'(W_NEXT));
    assign wr_mode      = h_wr_en && (widx == WIDX_W'(W_VSMODE));

    assign full_req    = wr_swrst && h_wdata[SWRST_FULL];
    assign core_req    = wr_swrst && h_wdata[SWRST_CORE];
    assign rst_req     = full_req || core_req;
    assign fetch_start = wr_start2 && h_wdata[ST2_FETCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_info_q <= '0;
            gp_q        <= '0;
            next_q      <= '0;
            mode_q      <= '0;
            idle_auth_q <= 1'b0;
            fetch_en_q  <= 1'b0;
            rst_full_q  <= 1'b0;
            rst_core_q  <= 1'b0;
        end else begin
            rst_full_q <= full_req;
            rst_core_q <= core_req;
            if (wr_host_info) host_info_q <= h_wdata;
            if (wr_gp)        gp_q        <= h_wdata;
            if (wr_next)      next_q      <= h_wdata;
            if (wr_mode)      mode_q      <= h_wdata[1:0];
            if (wr_start1)    idle_auth_q <= h_wdata[ST1_IDLE];
            if (wr_start2)    fetch_en_q  <= h_wdata[ST2_FETCH];
            if (rst_req)      fetch_en_q  <= 1'b0;
            if (full_req) begin
                host_info_q <= '0;
                gp_q        <= '0;
                next_q      <= '0;
                mode_q      <= '0;
                idle_auth_q <= 1'b0;
            end
        end
    end

    mbx_vsync_sel u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync_i    (vsync_i),
        .mode_i     (mode_q),
        .sw_trig_i  (wr_next),
        .fetch_evt_o(fetch_evt),
        .vsync_irq_o(vsync_irq_o)
    );

    mbx_fsm #(
        .PTR_W      (DATA_W),
        .RST_CYCLES (RST_CYCLES),
        .BOOT_CYCLES(BOOT_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rst_req_i    (rst_req),
        .fetch_start_i(fetch_start),
        .fetch_evt_i  (fetch_evt),
        .next_ptr_i   (next_q),
        .cur_ptr_o    (cur_ptr),
        .rst_done_o   (rst_done),
        .qinit_o      (qinit),
        .ready_o      (ready),
        .busy_o       (busy)
    );

    mbx_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_all_i   (full_req),
        .cp_set_i    (wr_irq_cp && h_wdata[0]),
        .host_clr_i  (wr_irq_host && h_wdata[0]),
        .cp_irq_req_i(cp_irq_req_i),
        .irq_cp_o    (irq_cp_o),
        .irq_host_o  (irq_host_o)
    );

    always_comb begin
        h_rdata = '0;
        unique case (widx)
            WIDX_W'(W_IRQ_CP):    h_rdata[0] = irq_cp_o;
            WIDX_W'(W_HOST_INFO): h_rdata = host_info_q;
            WIDX_W'(W_IRQ_HOST):  h_rdata[0] = irq_host_o;
            WIDX_W'(W_CP_INFO): begin
                h_rdata[INFO_READY] = ready;
                h_rdata[INFO_PROC]  = busy;
                h_rdata[INFO_QINIT] = qinit;
            end
            WIDX_W'(W_SWRST): begin
                h_rdata[SWRST_FULL] = rst_full_q;
                h_rdata[SWRST_CORE] = rst_core_q;
            end
            WIDX_W'(W_START1): begin
                h_rdata[ST1_DONE] = rst_done;
                h_rdata[ST1_IDLE] = idle_auth_q;
            end
            WIDX_W'(W_START2):    h_rdata[ST2_FETCH] = fetch_en_q;
            WIDX_W'(W_GPSTAT):    h_rdata = gp_q;
            WIDX_W'(W_NEXT):      h_rdata = next_q;
            WIDX_W'(W_CUR):       h_rdata = cur_ptr;
            WIDX_W'(W_VSMODE):    h_rdata[1:0] = mode_q;
            default:              h_rdata = '0;
        endcase
    end

    assign rst_full_o  = rst_full_q;
    assign rst_core_o  = rst_core_q;
    assign fetch_en_o  = fetch_en_q;
    assign host_info_o = host_info_q;
    assign cmd_ptr_o   = cur_ptr;

    // R2: reset pulses come only from a reset-register write
    assert_full_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_full_o |-> $past(wr_swrst));
    assert_core_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_core_o |-> $past(wr_swrst));
    // R4: a reset request always drops fetch enable
    assert_fetch_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !fetch_en_o);
endmodule

// File: tb/vid_cmd_mailbox_tb.sv
module vid_cmd_mailbox_tb;
    localparam int RSTC = 8;
    localparam int BOOTC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr_en = 1'b0;
    logic [7:0]  h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        vsync_i = 1'b0;
    logic        cp_irq_req_i = 1'b0;
    logic        rst_full_o, rst_core_o, fetch_en_o, irq_cp_o, irq_host_o, vsync_irq_o;
    logic [31:0] host_info_o, cmd_ptr_o;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vid_cmd_mailbox #(.ADDR_W(8), .DATA_W(32), .RST_CYCLES(RSTC), .BOOT_CYCLES(BOOTC)) u_dut (
        .clk(clk), .rst_n(rst_n), .h_wr_en(h_wr_en), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .vsync_i(vsync_i), .cp_irq_req_i(cp_irq_req_i),
        .rst_full_o(rst_full_o), .rst_core_o(rst_core_o), .fetch_en_o(fetch_en_o),
        .irq_cp_o(irq_cp_o), .irq_host_o(irq_host_o), .vsync_irq_o(vsync_irq_o),
        .host_info_o(host_info_o), .cmd_ptr_o(cmd_ptr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // drive at negedge, take effect at the next edge, return at the negedge after it
    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        h_addr = a; h_wdata = d; h_wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        h_wr_en = 1'b0; h_wdata = '0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        h_addr = a;
        #1 d = h_rdata;
    endtask

    task automatic vs_pulse(output logic irq_seen);
        vsync_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_seen = vsync_irq_o;
        vsync_i = 1'b0;
        cyc(1);
    endtask

    task automatic t_reset_state;
        logic [31:0] d;
        for (int a = 0; a <= 'h28; a += 4) begin
            hread(8'(a), d);
            chk("R1 reg after reset", d, 32'h0);
        end
        chk("R1 outputs after reset",
            {rst_full_o, rst_core_o, fetch_en_o, irq_cp_o, irq_host_o, vsync_irq_o}, 32'h0);
        chk("R1 cmd_ptr after reset", cmd_ptr_o, 32'h0);
    endtask

    task automatic t_full_reset;
        logic [31:0] d;
        hwrite(8'h04, 32'h1234);
        hwrite(8'h28, 32'h1);
        hwrite(8'h10, 32'h1);
        chk("R2 full pulse high", rst_full_o, 1);
        chk("R2 core stays low", rst_core_o, 0);
        cyc(1);
        chk("R2 full pulse self-clears", rst_full_o, 0);
        hread(8'h10, d);
        chk("R2 reset reg reads 0", d, 0);
        hread(8'h04, d);
        chk("R2 full clears host info", d, 0);
        hread(8'h28, d);
        chk("R2 full clears sync mode", d, 0);
        cyc(RSTC - 2);
        hread(8'h14, d);
        chk("R3 done still low", d, 0);
        cyc(1);
        hread(8'h14, d);
        chk("R3 done high after RST_CYCLES", d, 1);
    endtask

    task automatic t_startup_bits;
        logic [31:0] d;
        hwrite(8'h14, 32'h0);
        hread(8'h14, d);
        chk("R5 bit0 read-only", d, 32'h1);
        hwrite(8'h14, 32'h4);
        hread(8'h14, d);
        chk("R5 idle authorise set", d, 32'h5);
    endtask

    task automatic t_halt_ignores;
        logic irq;
        hwrite(8'h20, 32'h1000);
        vs_pulse(irq);
        chk("R10 no fetch while halted", cmd_ptr_o, 0);
        chk("R9 sync irq in mode 0", irq, 1);
    endtask

    task automatic t_boot;
        logic [31:0] d;
        logic irq;
        hwrite(8'h18, 32'h2);
        chk("R4 fetch_en high", fetch_en_o, 1);
        vs_pulse(irq);
        chk("R10 no fetch while booting", cmd_ptr_o, 0);
        cyc(BOOTC - 3);
        hread(8'h0C, d);
        chk("R4 not ready before BOOT_CYCLES", d, 0);
        cyc(1);
        hread(8'h0C, d);
        chk("R4 ready after BOOT_CYCLES", d, 32'hA000);
    endtask

    task automatic t_hw_mode;
        logic [31:0] d;
        logic irq;
        vs_pulse(irq);
        chk("R6 promote on vsync", cmd_ptr_o, 32'h1000);
        hread(8'h0C, d);
        chk("R6 processing flag", d, 32'h6000);
        hwrite(8'h20, 32'h2000);
        cyc(2);
        chk("R6 post alone does not fetch", cmd_ptr_o, 32'h1000);
        vs_pulse(irq);
        chk("R6 second promote", cmd_ptr_o, 32'h2000);
        hread(8'h24, d);
        chk("R6 active reg readback", d, 32'h2000);
        hwrite(8'h20, 32'h0);
        vs_pulse(irq);
        chk("R7 zero clears active", cmd_ptr_o, 0);
        hread(8'h0C, d);
        chk("R7 back to ready", d, 32'hA000);
    endtask

    task automatic t_sw_mode;
        logic irq;
        hwrite(8'h28, 32'h1);
        hwrite(8'h20, 32'h3000);
        chk("R8 fetch not yet at write edge", cmd_ptr_o, 0);
        cyc(1);
        chk("R8 fetch one cycle after post", cmd_ptr_o, 32'h3000);
        hwrite(8'h28, 32'h1);
        vs_pulse(irq);
        chk("R9 sync irq in mode 1", irq, 1);
        chk("R8 vsync ignored in sw mode", cmd_ptr_o, 32'h3000);
        hwrite(8'h28, 32'h3);
        vs_pulse(irq);
        chk("R9 sync irq suppressed in mode 3", irq, 0);
        hwrite(8'h20, 32'h4000);
        cyc(1);
        chk("R8 post fetches in mode 3", cmd_ptr_o, 32'h4000);
    endtask

    task automatic t_irqs;
        logic [31:0] d;
        hwrite(8'h00, 32'h1);
        chk("R11 doorbell pulse", irq_cp_o, 1);
        cyc(1);
        chk("R11 doorbell ends", irq_cp_o, 0);
        cp_irq_req_i = 1'b1;
        cyc(1);
        cp_irq_req_i = 1'b0;
        chk("R12 host irq set", irq_host_o, 1);
        hwrite(8'h08, 32'h0);
        hread(8'h08, d);
        chk("R12 write 0 keeps irq", d, 1);
        cp_irq_req_i = 1'b1;
        hwrite(8'h08, 32'h1);
        cp_irq_req_i = 1'b0;
        chk("R12 set wins over clear", irq_host_o, 1);
        hwrite(8'h08, 32'h1);
        chk("R12 host clear", irq_host_o, 0);
    endtask

    task automatic t_read_only;
        logic [31:0] d;
        hwrite(8'h24, 32'hDEAD);
        hread(8'h24, d);
        chk("R13 active reg ignores write", d, 32'h4000);
        hwrite(8'h0C, 32'hFFFF);
        hread(8'h0C, d);
        chk("R13 status ignores write", d, 32'h6000);
    endtask

    task automatic t_core_reset;
        logic [31:0] d;
        hwrite(8'h04, 32'h55);
        hwrite(8'h10, 32'h2);
        chk("R2 core pulse", rst_core_o, 1);
        chk("R2 no full pulse on core", rst_full_o, 0);
        chk("R2 core clears active", cmd_ptr_o, 0);
        chk("R2 core drops fetch_en", fetch_en_o, 0);
        chk("R2 core keeps host info", host_info_o, 32'h55);
        hread(8'h20, d);
        chk("R2 core keeps pending", d, 32'h4000);
        hread(8'h28, d);
        chk("R2 core keeps mode", d, 32'h3);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset_state();
        t_full_reset();
        t_startup_bits();
        t_halt_ignores();
        t_boot();
        t_hw_mode();
        t_sw_mode();
        t_irqs();
        t_read_only();
        t_core_reset();
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog act=running exp=done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule